// File: doc/BRIEF.md
# Deterministic Store-Buffered Thread Arbiter

The block gives a few hardware threads access to one shared word memory so that the final memory image and every value a thread reads depend only on each thread's own sequence of operations, never on when the requests arrive. Execution proceeds in rounds. In the parallel part of a round each thread may touch any address. Its stores go into a small private buffer, and its loads look in that buffer before falling through to shared memory, which stays frozen for the whole parallel part.

A thread leaves parallel mode for one of three reasons: it has used its per-round access allowance, it presents a synchronizing operation, or it presents a store that needs a new buffer slot when none is left. Once every thread has stopped, a commit engine writes the buffers to memory thread by thread in ascending ID order. A serial step then runs the held synchronizing operations one at a time, again in ascending ID order. Each of these is an atomic swap: it writes the thread's data and returns the previous memory word. All buffers are then emptied and the next round begins.

A request that was refused because its thread had stopped stays pending with valid held. It is served in a later round. A thread that drops valid without having stopped keeps the round open.

Top module: `detbuf_commit`

## Requirements
- R1: During the parallel part of a round the shared memory port never writes. A store is held in the issuing thread's buffer and is not visible through memory until that round's commit.
- R2: A load whose address matches an entry in the issuing thread's buffer returns the buffered word. Any other load returns the shared memory word.
- R3: A thread's buffered stores are invisible to loads from every other thread in the same round.
- R4: A store to an address already in the thread's buffer replaces that entry's data and does not take a new slot, so the latest value is the one committed.
- R5: Commit writes the buffers in ascending thread ID. When several threads stored to one address in a round, memory ends up with the value from the highest-numbered thread.
- R6: After QUANT accepted accesses in a round, a thread receives no further ready until the next round.
- R7: A synchronizing request (sync flag high) is never accepted in the parallel part. It ends that thread's parallel mode and is performed after commit as an atomic swap: memory gets the request data and the thread receives the previous word.
- R8: A store that misses a full buffer (BUFN entries) is not accepted. It ends the thread's parallel mode and is accepted in the next round. A store that hits a full buffer is still accepted.
- R9: Held synchronizing operations run strictly after commit, one per thread, in ascending thread ID. Each one sees the memory left by the previous one.
- R10: Out of reset no thread sees ready and the memory port does not write. At most one thread receives ready in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_valid | input | NT | Per-thread request valid |
| t_wr | input | NT | Per-thread store (1) or load (0) |
| t_sync | input | NT | Per-thread synchronizing swap request |
| t_addr | input | NT*AW | Per-thread word address, thread i in bits [i*AW +: AW] |
| t_wdata | input | NT*DW | Per-thread store or swap data |
| t_ready | output | NT | Per-thread acceptance; a handshake is valid and ready high at a clock edge |
| t_rdata | output | NT*DW | Per-thread load or swap result, valid while ready is high |
| mem_addr | output | AW | Shared memory address |
| mem_we | output | 1 | Shared memory write enable |
| mem_wdata | output | DW | Shared memory write data |
| mem_rdata | input | DW | Shared memory asynchronous read data |

## Verification
Every cycle, the embedded properties check four things: the memory port is quiet during the parallel part, only one thread holds ready, a synchronizing request is never accepted early, and the access counters and buffer fill levels stay inside their limits. They also check that the serial step is entered only from commit. The data-dependent behaviour needs the bench's directed rounds, each with a known starting memory. These cover forwarding from a thread's own buffer, isolation from other threads' buffers, coalescing of repeated stores, and highest-ID-wins at commit. They also cover deferral of a request past the quantum or past a full buffer, and the chain of swaps in ascending ID order.

// File: rtl/detbuf_commit.sv
module detbuf_commit #(
  parameter int NT    = 4,
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int BUFN  = 4,
  parameter int QUANT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NT-1:0]    t_valid,
  input  logic [NT-1:0]    t_wr,
  input  logic [NT-1:0]    t_sync,
  input  logic [NT*AW-1:0] t_addr,
  input  logic [NT*DW-1:0] t_wdata,
  output logic [NT-1:0]    t_ready,
  output logic [NT*DW-1:0] t_rdata,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_we,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata
);

  localparam int TW = (NT > 1) ? $clog2(NT) : 1;
  localparam int EW = (BUFN > 1) ? $clog2(BUFN) : 1;
  localparam int FW = $clog2(BUFN + 1);
  localparam int QW = $clog2(QUANT + 1);

  typedef enum logic [1:0] {PH_PAR, PH_COMMIT, PH_SYNC} phase_t;

  phase_t        ph;
  logic [TW-1:0] ct;
  logic [EW-1:0] ce;
  logic [NT-1:0] done, pend;
  logic [FW-1:0] fill [NT];
  logic [QW-1:0] used [NT];
  logic [AW-1:0] b_addr [NT][BUFN];
  logic [DW-1:0] b_data [NT][BUFN];

  logic [AW-1:0] a    [NT];
  logic [DW-1:0] wd   [NT];
  logic [EW-1:0] hidx [NT];
  logic [NT-1:0] hit, full, elig, gnt;
  logic [TW-1:0] gidx;

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      a[i]    = t_addr[i*AW +: AW];
      wd[i]   = t_wdata[i*DW +: DW];
      hit[i]  = 1'b0;
      hidx[i] = '0;
      for (int e = 0; e < BUFN; e++)
        if (FW'(e) < fill[i] && b_addr[i][e] == a[i]) begin
          hit[i]  = 1'b1;
          hidx[i] = EW'(e);
        end
      full[i] = (fill[i] == FW'(BUFN));
      elig[i] = (ph == PH_PAR) && t_valid[i] && !done[i] && !t_sync[i] &&
                !(t_wr[i] && !hit[i] && full[i]);
    end
    gnt  = '0;
    gidx = '0;
    for (int i = NT - 1; i >= 0; i--)
      if (elig[i]) begin
        gnt     = '0;
        gnt[i]  = 1'b1;
        gidx    = TW'(i);
      end
  end

  logic sync_fire;
  assign sync_fire = (ph == PH_SYNC) && pend[ct] && t_valid[ct];

  always_comb begin
    t_ready = '0;
    if (ph == PH_PAR) t_ready = gnt;
    else if (sync_fire) t_ready[ct] = 1'b1;
    for (int i = 0; i < NT; i++)
      t_rdata[i*DW +: DW] = (ph == PH_PAR && hit[i]) ? b_data[i][hidx[i]] : mem_rdata;
  end

  always_comb begin
    case (ph)
      PH_COMMIT: begin
        mem_addr  = b_addr[ct][ce];
        mem_we    = FW'(ce) < fill[ct];
        mem_wdata = b_data[ct][ce];
      end
      PH_SYNC: begin
        mem_addr  = a[ct];
        mem_we    = sync_fire;
        mem_wdata = wd[ct];
      end
      default: begin
        mem_addr  = a[gidx];
        mem_we    = 1'b0;
        mem_wdata = wd[gidx];
      end
    endcase
  end

  always_ff @(posedge clk)
    for (int i = 0; i < NT; i++)
      if (gnt[i] && t_wr[i]) begin
        if (hit[i]) b_data[i][hidx[i]] <= wd[i];
        else begin
          b_addr[i][EW'(fill[i])] <= a[i];
          b_data[i][EW'(fill[i])] <= wd[i];
        end
      end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_PAR;
      ct   <= '0;
      ce   <= '0;
      done <= '0;
      pend <= '0;
      for (int i = 0; i < NT; i++) begin
        fill[i] <= '0;
        used[i] <= '0;
      end
    end else begin
      case (ph)
        PH_PAR: begin
          for (int i = 0; i < NT; i++) begin
            if (gnt[i]) begin
              used[i] <= used[i] + 1'b1;
              if (t_wr[i] && !hit[i]) fill[i] <= fill[i] + 1'b1;
              if (used[i] == QW'(QUANT - 1)) done[i] <= 1'b1;
            end else if (t_valid[i] && !done[i]) begin
              if (t_sync[i]) begin
                done[i] <= 1'b1;
                pend[i] <= 1'b1;
              end else if (t_wr[i] && !hit[i] && full[i]) begin
                done[i] <= 1'b1;
              end
            end
          end
          if (&done) begin
            ph <= PH_COMMIT;
            ct <= '0;
            ce <= '0;
          end
        end
        PH_COMMIT: begin
          if (ce == EW'(BUFN - 1)) begin
            ce <= '0;
            if (ct == TW'(NT - 1)) begin
              ct <= '0;
              ph <= PH_SYNC;
            end else ct <= ct + 1'b1;
          end else ce <= ce + 1'b1;
        end
        default: begin
          if (!pend[ct] || t_valid[ct]) begin
            pend[ct] <= 1'b0;
            if (ct == TW'(NT - 1)) begin
              ct   <= '0;
              ph   <= PH_PAR;
              done <= '0;
              pend <= '0;
              for (int i = 0; i < NT; i++) begin
                fill[i] <= '0;
                used[i] <= '0;
              end
            end else ct <= ct + 1'b1;
          end
        end
      endcase
    end
  end

  AST_PAR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_PAR) |-> !mem_we); // R1

  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(t_ready)); // R10

  AST_SYNC_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph == PH_SYNC) |-> $past(ph == PH_COMMIT)); // R9

  for (genvar gi = 0; gi < NT; gi++) begin : g_chk
    AST_SYNC_NOT_PARALLEL: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_PAR && t_valid[gi] && t_sync[gi]) |-> !t_ready[gi]); // R7

    AST_QUANT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (used[gi] == QW'(QUANT) && ph == PH_PAR) |-> !t_ready[gi]); // R6

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill[gi] <= FW'(BUFN)); // R8
  end

endmodule

// File: tb/detbuf_commit_bench.sv
`timescale 1ns/100ps
module detbuf_commit_bench;

  localparam int NT = 4, AW = 4, DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NT-1:0]    t_valid, t_wr, t_sync, t_ready;
  logic [NT*AW-1:0] t_addr;
  logic [NT*DW-1:0] t_wdata, t_rdata;
  logic [AW-1:0]    mem_addr;
  logic             mem_we;
  logic [DW-1:0]    mem_wdata, mem_rdata;

  detbuf_commit u_detbuf_commit (
    .clk(clk), .rst_n(rst_n), .t_valid(t_valid), .t_wr(t_wr), .t_sync(t_sync),
    .t_addr(t_addr), .t_wdata(t_wdata), .t_ready(t_ready), .t_rdata(t_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem [16];
  logic mem_init = 1'b1;
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk)
    if (mem_init) for (int k = 0; k < 16; k++) mem[k] <= 8'hA0 + 8'(k);
    else if (mem_we) mem[mem_addr] <= mem_wdata;

  int checks = 0, fails = 0;
  logic [25:0] prog [NT][$];
  logic [11:0] expq [NT][$];
  logic [NT-1:0] busyv;

  for (genvar g = 0; g < NT; g++) begin : g_drv
    logic v = 1'b0, w = 1'b0, s = 1'b0, busy = 1'b0;
    logic [AW-1:0] ad = '0;
    logic [DW-1:0] dt = '0;
    logic [25:0] it;
    assign t_valid[g] = v;
    assign t_wr[g]    = w;
    assign t_sync[g]  = s;
    assign t_addr[g*AW +: AW]  = ad;
    assign t_wdata[g*DW +: DW] = dt;
    assign busyv[g] = busy;
    initial forever begin
      @(negedge clk);
      if (prog[g].size() == 0) begin
        v = 1'b0;
        busy = 1'b0;
      end else begin
        logic r;
        it = prog[g].pop_front();
        busy = 1'b1;
        v  = 1'b1;
        w  = (it[21:20] == 2'd1);
        s  = (it[21:20] == 2'd2);
        ad = it[19:16];
        dt = it[15:8];
        if (it[21:20] != 2'd1) expq[g].push_back({it[25:22], it[7:0]});
        r = 1'b0;
        while (!r) begin
          #1.5;
          r = t_ready[g];
          @(posedge clk);
          if (!r) @(negedge clk);
        end
      end
    end
  end

  initial forever begin
    @(negedge clk);
    #1.5;
    for (int g = 0; g < NT; g++)
      if (rst_n && t_valid[g] && t_ready[g] && !t_wr[g]) begin
        logic [11:0] e;
        checks++;
        if (expq[g].size() == 0) begin
          fails++;
          $display("FAIL unexpected result thread %0d rdata=%h expected none", g, t_rdata[g*DW +: DW]);
        end else begin
          e = expq[g].pop_front();
          if (t_rdata[g*DW +: DW] !== e[7:0]) begin
            fails++;
            $display("FAIL R%0d thread %0d rdata=%h expected %h", e[11:8], g, t_rdata[g*DW +: DW], e[7:0]);
          end
        end
      end
  end

  task automatic op(int th, int rq, int kind, int addr, int data, int ex);
    prog[th].push_back({4'(rq), 2'(kind), 4'(addr), 8'(data), 8'(ex)});
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] ex);
    checks++;
    if (act !== ex) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, ex);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mem_init = 1'b1;
    repeat (3) @(negedge clk);
    mem_init = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    int n;
    do begin
      @(negedge clk);
      #1;
      n = 0;
      for (int g = 0; g < NT; g++) n += prog[g].size();
    end while (n != 0 || busyv != '0);
    repeat (3) @(negedge clk);
  endtask

  task automatic two_syncs();
    op(1, 9, 2, 9, 8'h01, 8'hA9);
    op(2, 9, 2, 10, 8'h02, 8'hAA);
    op(2, 9, 2, 10, 8'h05, 8'h02);
    op(3, 9, 2, 11, 8'h03, 8'hAB);
    op(3, 9, 2, 11, 8'h06, 8'h03);
  endtask

  initial begin
    do_reset();
    #1;
    chk("R10 ready after reset", {4'b0, t_ready}, 8'h00);
    chk("R10 mem_we after reset", {7'b0, mem_we}, 8'h00);

    // S2: forwarding (R2), isolation (R3), coalescing (R4), highest ID wins (R5), swaps (R7)
    op(0, 1, 1, 3, 8'h11, 0);
    op(0, 2, 0, 3, 0, 8'h11);
    op(0, 7, 2, 15, 8'h00, 8'hAF);
    op(1, 3, 0, 3, 0, 8'hA3);
    op(1, 1, 1, 3, 8'h22, 0);
    op(1, 7, 2, 14, 8'h01, 8'hAE);
    op(2, 4, 1, 3, 8'h33, 0);
    op(2, 4, 1, 3, 8'h34, 0);
    op(2, 7, 2, 13, 8'h02, 8'hAD);
    op(3, 2, 0, 5, 0, 8'hA5);
    op(3, 7, 2, 12, 8'h03, 8'hAC);
    wait_done();
    chk("R5 R4 mem[3] highest thread, latest store", mem[3], 8'h34);
    chk("R7 swap mem[15]", mem[15], 8'h00);
    chk("R7 swap mem[14]", mem[14], 8'h01);
    chk("R7 swap mem[13]", mem[13], 8'h02);
    chk("R7 swap mem[12]", mem[12], 8'h03);
    chk("R1 unstored word untouched", mem[5], 8'hA5);

    // S3: chained swaps on one address in ascending ID (R9)
    do_reset();
    for (int g = 0; g < NT; g++) op(g, 9, 2, 7, 8'h50 + g, (g == 0) ? 8'hA7 : 8'h4F + g);
    wait_done();
    chk("R9 final swap value", mem[7], 8'h53);

    // S4: quantum exhaustion defers the seventh access (R6)
    do_reset();
    op(0, 1, 1, 1, 8'h77, 0);
    for (int k = 0; k < 5; k++) op(0, 2, 0, 2, 0, 8'hA2);
    op(0, 6, 0, 9, 0, 8'h01);
    op(0, 7, 2, 6, 8'h00, 8'hA6);
    two_syncs();
    op(1, 9, 2, 9, 8'h07, 8'h01);
    wait_done();
    chk("R6 R1 committed store", mem[1], 8'h77);
    chk("R9 second-round swap", mem[9], 8'h07);
    chk("R9 thread2 swap", mem[10], 8'h05);

    // S5: full buffer, hit accepted, miss deferred (R8)
    do_reset();
    for (int k = 0; k < 4; k++) op(0, 8, 1, k, 8'h60 + k, 0);
    op(0, 8, 1, 0, 8'h70, 0);
    op(0, 8, 1, 4, 8'h64, 0);
    op(0, 8, 0, 0, 0, 8'h70);
    op(0, 2, 0, 4, 0, 8'h64);
    op(0, 7, 2, 6, 8'h00, 8'hA6);
    op(1, 9, 2, 9, 8'h01, 8'hA9);
    op(1, 8, 0, 4, 0, 8'hA4);
    op(1, 9, 2, 9, 8'h02, 8'h01);
    op(2, 9, 2, 10, 8'h02, 8'hAA);
    op(2, 9, 2, 10, 8'h05, 8'h02);
    op(3, 9, 2, 11, 8'h03, 8'hAB);
    op(3, 9, 2, 11, 8'h06, 8'h03);
    wait_done();
    chk("R8 hit on full buffer", mem[0], 8'h70);
    chk("R8 entry 3", mem[3], 8'h63);
    chk("R8 deferred store committed", mem[4], 8'h64);
    chk("R9 thread1 swaps", mem[9], 8'h02);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule